// File: doc/BRIEF.md
# Periodic-Error-Tolerant Block Error Counter

This block counts errored 64-bit blocks reported by a receive-side pattern checker that runs without aligning its local scrambler to the transmitter's seed reloads. The transmitter reloads a new seed every 128 blocks. Each reload makes exactly one received block miscompare, so a perfect link still shows four errors in every full pattern cycle. The block removes these errors from the count without any extra framing in the pattern.

The counter first learns where the reload falls. It does this from the spacing of errors: four errors in a row, each exactly one reload period after the one before, fix the phase. From then on a block-position counter marks the one expected-error slot in every period. Errors in that slot are dropped from the masked count, and all other errors are counted. A raw count of every errored block is also kept. Both counts saturate, and a synchronous clear input zeroes them. The per-block error flag comes from outside this block. A block that matches either the expected data or its bitwise inverse must arrive here as error-free.

Top module: `blk_err_tally`

## Requirements
- R1: After reset, `locked` is 0 and both `raw_cnt` and `err_cnt` are 0.
- R2: Every cycle with `blk_vld`=1 and `blk_err`=1 adds one to `raw_cnt`, visible after the next clock edge. The count is per block, not per bit.
- R3: A cycle with `blk_vld`=0 changes no count and does not advance the search spacing or the locked slot position, whatever `blk_err` is.
- R4: While unlocked, every errored valid block also adds one to `err_cnt`.
- R5: `locked` rises after the clock edge that samples the fourth errored valid block of a chain in which each error comes exactly PERIOD (default 128) valid blocks after the previous one.
- R6: While unlocked, an error that arrives earlier than PERIOD valid blocks after the last candidate error breaks the chain. That error becomes the first candidate of a new chain.
- R7: While unlocked, if PERIOD valid blocks pass after a candidate error without a new error, the chain is dropped. The next error becomes the first candidate.
- R8: Once locked, an errored valid block that lies a whole multiple of PERIOD valid blocks after the fourth chain error is counted in `raw_cnt` but not in `err_cnt`.
- R9: Once locked, an errored valid block in any other position adds one to both counts.
- R10: `locked` stays 1 until reset. `clr` does not change it.
- R11: Each count holds at 2^CNT_W-1 instead of wrapping.
- R12: `clr`=1 makes both counts 0 after the next edge. It takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of both counts |
| blk_vld | input | 1 | A received block is presented this cycle |
| blk_err | input | 1 | The presented block miscompared |
| locked | output | 1 | Reload period phase has been found |
| err_cnt | output | CNT_W | Errored blocks outside the expected slot |
| raw_cnt | output | CNT_W | All errored blocks |

## Verification
The assertions check the cycle-local rules on every cycle: counts only move on valid blocks or on a clear, the raw count steps by at most one, the masked count never exceeds the raw count, `locked` never falls, and lock is entered only on an errored valid block. Other behaviours depend on long block histories and only the bench scenarios can show them. These are the exact 128-block spacing that leads to lock, the restart of the chain after an early or missing error, and the placement of the masked slot after idle gaps.

// File: rtl/blk_err_pkg.sv
// Shared constants and types for the block error counter.
// Assumes nothing beyond being compiled before the modules that import it.
package blk_err_pkg;
    parameter int unsigned PERIOD_DEF = 128;
    parameter int unsigned HITS_DEF   = 4;
    parameter int unsigned CNT_W_DEF  = 16;

    typedef enum logic {
        SRCH  = 1'b0,
        LOCKD = 1'b1
    } srch_state_e;
endpackage

// File: rtl/blk_period_search.sv
// Finds the reload phase from error spacing: it declares lock after HITS
// errors, each PERIOD valid blocks after the previous one.
// Assumes PERIOD >= 2 and HITS >= 2. Lock is held until reset.
module blk_period_search
    import blk_err_pkg::*;
#(
    parameter int unsigned PERIOD = PERIOD_DEF,
    parameter int unsigned HITS   = HITS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_vld,
    input  logic blk_err,
    output logic locked,
    output logic lock_evt
);
    localparam int unsigned GW = $clog2(PERIOD);
    localparam int unsigned HW = $clog2(HITS + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(PERIOD - 1);
    localparam logic [HW-1:0] HIT_LAST = HW'(HITS - 1);

    srch_state_e   state_q;
    logic [HW-1:0] hits_q;
    logic [GW-1:0] gap_q;
    logic          on_time;

    // An error now sits exactly one period after the previous candidate.
    assign on_time  = (hits_q != '0) && (gap_q == GAP_LAST);
    assign lock_evt = (state_q == SRCH) && blk_vld && blk_err && on_time
                      && (hits_q == HIT_LAST);
    assign locked   = (state_q == LOCKD);

    // Candidate chain tracking and the lock decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRCH;
            hits_q  <= '0;
            gap_q   <= '0;
        end else if (state_q == SRCH && blk_vld) begin
            if (blk_err) begin
                gap_q <= '0;
                if (lock_evt) begin
                    state_q <= LOCKD;
                    hits_q  <= '0;
                end else if (on_time) begin
                    hits_q <= hits_q + HW'(1);
                end else begin
                    hits_q <= HW'(1);
                end
            end else if (gap_q == GAP_LAST) begin
                hits_q <= '0;
            end else begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end
endmodule

// File: rtl/blk_phase_ctr.sv
// Tracks the block position inside the reload period once locked. Position
// zero is the expected-error slot.
// Assumes lock_evt pulses on the block that completed the lock chain.
module blk_phase_ctr
    import blk_err_pkg::*;
#(
    parameter int unsigned PERIOD = PERIOD_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_vld,
    input  logic lock_evt,
    input  logic locked,
    output logic mask_slot
);
    localparam int unsigned PW = $clog2(PERIOD);
    localparam logic [PW-1:0] POS_LAST = PW'(PERIOD - 1);

    logic [PW-1:0] pos_q;

    // The current block falls in the slot the reload corrupts.
    assign mask_slot = locked && (pos_q == '0);

    // Position counter: it is phased on lock and steps once per valid block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (lock_evt) begin
            pos_q <= PW'(1);
        end else if (locked && blk_vld) begin
            pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + PW'(1);
        end
    end
endmodule

// File: rtl/blk_sat_ctr.sv
// Saturating event counter with a synchronous clear.
// Assumes inc is a single-cycle qualified event. clr has priority over inc.
module blk_sat_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count up to all-ones, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/blk_err_tally.sv
// Top level: counts errored blocks and drops the one expected error per
// reload period once the period phase has been learned.
// Assumes blk_err is meaningful only when blk_vld is high.
module blk_err_tally
    import blk_err_pkg::*;
#(
    parameter int unsigned PERIOD = PERIOD_DEF,
    parameter int unsigned HITS   = HITS_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             blk_vld,
    input  logic             blk_err,
    output logic             locked,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] raw_cnt
);
    localparam int unsigned NCNT = 2;

    logic             lock_evt;
    logic             mask_slot;
    logic             hit;
    logic [NCNT-1:0]  inc_v;
    logic [CNT_W-1:0] cnt_v [NCNT];

    blk_period_search #(.PERIOD(PERIOD), .HITS(HITS)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_vld  (blk_vld),
        .blk_err  (blk_err),
        .locked   (locked),
        .lock_evt (lock_evt)
    );

    blk_phase_ctr #(.PERIOD(PERIOD)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_vld   (blk_vld),
        .lock_evt  (lock_evt),
        .locked    (locked),
        .mask_slot (mask_slot)
    );

    // Index 0 counts every error, index 1 counts errors outside the slot.
    assign hit      = blk_vld && blk_err;
    assign inc_v[0] = hit;
    assign inc_v[1] = hit && !mask_slot;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        blk_sat_ctr #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc_v[i]),
            .cnt   (cnt_v[i])
        );
    end

    assign raw_cnt = cnt_v[0];
    assign err_cnt = cnt_v[1];
endmodule

// File: rtl/blk_err_tally_chk.sv
// Cycle-level checks on the counter ports, bound to blk_err_tally.
// Assumes the port names of the top module.
module blk_err_tally_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             blk_vld,
    input logic             blk_err,
    input logic             locked,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] raw_cnt
);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_vld && !clr) |=> ($stable(raw_cnt) && $stable(err_cnt)));

    // R2
    raw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (raw_cnt == $past(raw_cnt)) || (raw_cnt == $past(raw_cnt) + CNT_W'(1)));

    // R8
    mask_le_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= raw_cnt);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R5
    lock_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(blk_vld && blk_err));

    // R12
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (raw_cnt == '0) && (err_cnt == '0));
endmodule

bind blk_err_tally blk_err_tally_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/blk_err_tally_bench.sv
module blk_err_tally_bench;
    localparam int CW = 6;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          blk_vld = 1'b0;
    logic          blk_err = 1'b0;
    logic          locked;
    logic [CW-1:0] err_cnt;
    logic [CW-1:0] raw_cnt;

    int n_chk = 0;
    int n_bad = 0;

    blk_err_tally #(.PERIOD(128), .HITS(4), .CNT_W(CW)) u_blk_err_tally (
        .clk(clk), .rst_n(rst_n), .clr(clr), .blk_vld(blk_vld),
        .blk_err(blk_err), .locked(locked), .err_cnt(err_cnt), .raw_cnt(raw_cnt)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clr = 1'b0; blk_vld = 1'b0; blk_err = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One valid block. The result is sampled at the following falling edge.
    task automatic blk(input bit e);
        @(negedge clk);
        blk_vld = 1'b1; blk_err = e;
        @(negedge clk);
        blk_vld = 1'b0; blk_err = 1'b0;
    endtask

    // Clean valid blocks back to back.
    task automatic clean(input int n);
        @(negedge clk);
        blk_vld = 1'b1; blk_err = 1'b0;
        repeat (n) @(negedge clk);
        blk_vld = 1'b0;
    endtask

    // Cycles without a valid block, with the error flag raised.
    task automatic idle(input int n);
        @(negedge clk);
        blk_vld = 1'b0; blk_err = 1'b1;
        repeat (n) @(negedge clk);
        blk_err = 1'b0;
    endtask

    // An error exactly one period after the previous one.
    task automatic next_period_err();
        clean(127);
        blk(1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 locked", int'(locked), 0);
        chk("R1 raw_cnt", int'(raw_cnt), 0);
        chk("R1 err_cnt", int'(err_cnt), 0);
    endtask

    task automatic t_unlocked();
        do_reset();
        blk(1'b1); clean(4); blk(1'b1); clean(4); blk(1'b1);
        chk("R2 raw_cnt", int'(raw_cnt), 3);
        chk("R4 err_cnt", int'(err_cnt), 3);
        chk("R4 locked", int'(locked), 0);
        idle(10);
        chk("R3 raw_cnt idle", int'(raw_cnt), 3);
        chk("R3 err_cnt idle", int'(err_cnt), 3);
    endtask

    task automatic t_lock();
        do_reset();
        blk(1'b1);
        next_period_err();
        next_period_err();
        chk("R5 not yet", int'(locked), 0);
        next_period_err();
        chk("R5 locked", int'(locked), 1);
        chk("R4 err_cnt at lock", int'(err_cnt), 4);
        next_period_err();
        chk("R8 raw_cnt slot", int'(raw_cnt), 5);
        chk("R8 err_cnt slot", int'(err_cnt), 4);
        clean(9); blk(1'b1);
        chk("R9 raw_cnt", int'(raw_cnt), 6);
        chk("R9 err_cnt", int'(err_cnt), 5);
        idle(20);
        clean(117); blk(1'b1);
        chk("R3 R8 raw_cnt after idle", int'(raw_cnt), 7);
        chk("R3 R8 err_cnt after idle", int'(err_cnt), 5);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R12 raw_cnt", int'(raw_cnt), 0);
        chk("R12 err_cnt", int'(err_cnt), 0);
        chk("R10 locked after clr", int'(locked), 1);
    endtask

    task automatic t_early();
        do_reset();
        blk(1'b1);
        next_period_err();
        next_period_err();
        clean(121); blk(1'b1);
        chk("R6 early err", int'(locked), 0);
        next_period_err();
        next_period_err();
        chk("R6 chain of three", int'(locked), 0);
        next_period_err();
        chk("R6 relock", int'(locked), 1);
    endtask

    task automatic t_miss();
        do_reset();
        blk(1'b1);
        next_period_err();
        clean(255); blk(1'b1);
        next_period_err();
        next_period_err();
        chk("R7 missed err", int'(locked), 0);
        next_period_err();
        chk("R7 relock", int'(locked), 1);
    endtask

    task automatic t_sat();
        do_reset();
        @(negedge clk);
        blk_vld = 1'b1; blk_err = 1'b1;
        repeat (MAXC + 7) @(negedge clk);
        blk_vld = 1'b0; blk_err = 1'b0;
        chk("R11 raw_cnt", int'(raw_cnt), MAXC);
        chk("R11 err_cnt", int'(err_cnt), MAXC);
        @(negedge clk);
        clr = 1'b1; blk_vld = 1'b1; blk_err = 1'b1;
        @(negedge clk);
        clr = 1'b0; blk_vld = 1'b0; blk_err = 1'b0;
        chk("R12 clr priority raw", int'(raw_cnt), 0);
        chk("R12 clr priority err", int'(err_cnt), 0);
    endtask

    initial begin
        t_reset();
        t_unlocked();
        t_lock();
        t_early();
        t_miss();
        t_sat();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule